// File: doc/BRIEF.md
# S/PDIF Sub-frame Word Formatter

The formatter turns decoded S/PDIF sub-frames into 32-bit words for a receive data register. Each incoming sub-frame brings a 24-bit audio sample, a parity-error flag, the validity, user and channel-status bits, and a 2-bit preamble type. A format code picks one of three layouts: right-aligned, left-aligned, or packed, where two 16-bit samples share one word. Four independent masks can force chosen status fields to zero before they are stored.

Finished words go into a single holding register with a not-empty flag. A read strobe empties the register. If a word completes while the register is still full, the new word is dropped and a sticky overrun flag is set. An optional DMA request follows the not-empty flag. In stereo mode, once software clears an overrun, sub-frames are skipped until the next channel-A sub-frame. This keeps every later word, and every packed pair, starting on the left channel.

Top module: `spdif_word_formatter`

## Requirements
- R1: With format code 0 a word carries the sample in [23:0], parity error in [24], validity in [25], user in [26], channel status in [27], preamble type in [29:28] and zeros in [31:30].
- R2: With format code 1 a word carries the sample in [31:8], parity error in [0], validity in [1], user in [2], channel status in [3], preamble type in [5:4] and zeros in [7:6].
- R3: With format code 2, sample bits [23:8] of the first sub-frame of a pair go to [15:0] and those of the second go to [31:16], with no status bits; only the second sub-frame completes a word.
- R4: Format code 3 is reserved: accepted sub-frames produce no word and leave the not-empty flag clear.
- R5: Each of the parity, validity, channel-status/user and preamble-type masks, when set, forces only its own field(s) to zero in formats 0 and 1.
- R6: A completed word is visible on the data output with the not-empty flag set on the clock edge that samples its last sub-frame. A read strobe clears the flag. A read strobe and a new word in the same cycle load the new word, keep the flag set and raise no overrun.
- R7: A word completed while the flag is set and no read strobe is present is dropped. The held word stays unchanged, and a sticky overrun flag is set that only the overrun-clear input removes.
- R8: The DMA request equals the not-empty flag while DMA is enabled and is low while DMA is disabled.
- R9: In stereo mode, after an overrun is cleared, sub-frames are discarded until one arrives with a channel-A preamble type (2'b01 block start or 2'b10), and packing restarts at that sub-frame. Type 2'b11 marks channel B.
- R10: In mono mode, clearing an overrun causes no realignment: the next sub-frame of any channel is used.
- R11: After reset the data output, not-empty flag, overrun flag and DMA request are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sf_valid | input | 1 | Sub-frame present this cycle |
| sf_sample | input | 24 | Audio sample |
| sf_perr | input | 1 | Parity error of the sub-frame |
| sf_valbit | input | 1 | Validity bit |
| sf_userbit | input | 1 | User bit |
| sf_csbit | input | 1 | Channel-status bit |
| sf_ptype | input | 2 | Preamble type (01, 10 channel A; 11 channel B) |
| cfg_fmt | input | 2 | Layout code 0/1/2, 3 reserved |
| cfg_mask_par | input | 1 | Zero the parity-error bit |
| cfg_mask_val | input | 1 | Zero the validity bit |
| cfg_mask_cu | input | 1 | Zero the channel-status and user bits |
| cfg_mask_pt | input | 1 | Zero the preamble-type bits |
| cfg_stereo | input | 1 | Realign on channel A after an overrun clear |
| cfg_dma_en | input | 1 | Enable DMA request |
| rd_strobe | input | 1 | Read of the holding register |
| ovr_clr | input | 1 | Clear the overrun flag |
| dr_word | output | 32 | Holding register contents |
| dr_nempty | output | 1 | Holding register full |
| ovr_flag | output | 1 | Sticky overrun |
| dma_req | output | 1 | DMA request |

## Verification
Two events can land on the same edge: a read strobe emptying the holding register and a newly completed word. The bench fills the register, then raises a read strobe together with a new sub-frame. The scoreboard must see the old word on the read and the new word on the next read, with the not-empty flag still set and no overrun. A second case holds the read strobe back on that edge. There the scoreboard expects the old word only, and the overrun flag must be set and stay set.

// File: rtl/spdif_fmt_pkg.sv
package spdif_fmt_pkg;

   typedef enum logic [1:0] {
      FMT_RIGHT  = 2'd0,
      FMT_LEFT   = 2'd1,
      FMT_PACKED = 2'd2,
      FMT_RSVD   = 2'd3
   } fmt_e;

   localparam int STAT_W = 6;

   typedef struct packed {
      logic [1:0] pt;
      logic       cs;
      logic       user;
      logic       valid;
      logic       perr;
   } stat_t;

   function automatic logic is_chan_a(input logic [1:0] pt);
      return (pt == 2'b01) || (pt == 2'b10);
   endfunction

endpackage

// File: rtl/spdif_fmt_align.sv
module spdif_fmt_align
   import spdif_fmt_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sf_valid_i,
   input  logic [1:0] pt_i,
   input  logic       stereo_i,
   input  logic       ovr_i,
   input  logic       ovr_clr_i,
   output logic       accept_o,
   output logic       hunting_o
);

   logic hunt_q;
   logic chan_a;

   assign chan_a    = is_chan_a(pt_i);
   assign accept_o  = sf_valid_i && (!hunt_q || chan_a);
   assign hunting_o = hunt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hunt_q <= 1'b0;
      end else if (!stereo_i) begin
         hunt_q <= 1'b0;
      end else if (ovr_i && ovr_clr_i) begin
         hunt_q <= 1'b1;
      end else if (hunt_q && sf_valid_i && chan_a) begin
         hunt_q <= 1'b0;
      end
   end

   // R9: leaving the hunt needs a channel-A sub-frame
   p_hunt_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(hunt_q) && $past(stereo_i)) |-> $past(sf_valid_i && is_chan_a(pt_i)));

   // R10: mono mode never hunts
   p_mono_no_hunt_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !stereo_i |=> !hunt_q);

endmodule

// File: rtl/spdif_fmt_build.sv
module spdif_fmt_build
   import spdif_fmt_pkg::*;
#(
   parameter int SAMPLE_W = 24,
   parameter int WORD_W   = 32,
   parameter int PACK_W   = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                accept_i,
   input  logic                resync_i,
   input  logic [1:0]          fmt_i,
   input  logic [SAMPLE_W-1:0] sample_i,
   input  stat_t               stat_i,
   input  logic                mask_par_i,
   input  logic                mask_val_i,
   input  logic                mask_cu_i,
   input  logic                mask_pt_i,
   output logic                word_ready_o,
   output logic [WORD_W-1:0]   word_o
);

   localparam int PAD_R = WORD_W - SAMPLE_W - STAT_W;
   localparam int PAD_L = WORD_W - SAMPLE_W - STAT_W;
   localparam int DROP  = SAMPLE_W - PACK_W;

   if (WORD_W < SAMPLE_W + STAT_W) begin : g_bad_word
      $error("word too narrow for sample and status");
   end
   if (2 * PACK_W != WORD_W) begin : g_bad_pack
      $error("two packed samples must fill one word");
   end
   if (PACK_W > SAMPLE_W) begin : g_bad_half
      $error("packed sample wider than sample");
   end

   stat_t               stat_m;
   logic                phase_q;
   logic                phase_eff;
   logic [PACK_W-1:0]   lo_q;
   logic [PACK_W-1:0]   top_bits;
   logic [WORD_W-1:0]   w_right;
   logic [WORD_W-1:0]   w_left;
   logic [WORD_W-1:0]   w_pack;

   always_comb begin
      stat_m       = stat_i;
      stat_m.perr  = stat_i.perr  & ~mask_par_i;
      stat_m.valid = stat_i.valid & ~mask_val_i;
      stat_m.user  = stat_i.user  & ~mask_cu_i;
      stat_m.cs    = stat_i.cs    & ~mask_cu_i;
      stat_m.pt    = stat_i.pt    & {2{~mask_pt_i}};
   end

   assign top_bits  = sample_i[SAMPLE_W-1 -: PACK_W];
   assign phase_eff = resync_i ? 1'b0 : phase_q;

   if (PAD_R > 0) begin : g_pad
      assign w_right = {{PAD_R{1'b0}}, stat_m, sample_i};
      assign w_left  = {sample_i, {PAD_L{1'b0}}, stat_m};
   end else begin : g_nopad
      assign w_right = {stat_m, sample_i};
      assign w_left  = {sample_i, stat_m};
   end

   assign w_pack = {top_bits, lo_q};

   always_comb begin
      word_ready_o = 1'b0;
      word_o       = '0;
      unique case (fmt_e'(fmt_i))
         FMT_RIGHT: begin
            word_ready_o = accept_i;
            word_o       = w_right;
         end
         FMT_LEFT: begin
            word_ready_o = accept_i;
            word_o       = w_left;
         end
         FMT_PACKED: begin
            word_ready_o = accept_i && phase_eff;
            word_o       = w_pack;
         end
         default: begin
            word_ready_o = 1'b0;
            word_o       = '0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= 1'b0;
         lo_q    <= '0;
      end else if (fmt_i != FMT_PACKED) begin
         phase_q <= 1'b0;
      end else if (accept_i) begin
         phase_q <= ~phase_eff;
         if (!phase_eff) lo_q <= top_bits;
      end else if (resync_i) begin
         phase_q <= 1'b0;
      end
   end

   // R4: the reserved code never completes a word
   p_rsvd_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (fmt_i == FMT_RSVD) |-> !word_ready_o);

   // R3: a packed word is only completed on the second half of a pair
   p_pack_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (fmt_i == FMT_PACKED && accept_i && !resync_i && !phase_q) |-> !word_ready_o);

   logic unused_low;
   if (DROP > 0) begin : g_unused
      assign unused_low = ^sample_i[DROP-1:0];
   end else begin : g_nounused
      assign unused_low = 1'b0;
   end

endmodule

// File: rtl/spdif_fmt_hold.sv
module spdif_fmt_hold #(
   parameter int WORD_W  = 32,
   parameter bit GEN_DMA = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              word_ready_i,
   input  logic [WORD_W-1:0] word_i,
   input  logic              rd_i,
   input  logic              ovr_clr_i,
   input  logic              dma_en_i,
   output logic [WORD_W-1:0] word_o,
   output logic              nempty_o,
   output logic              ovr_o,
   output logic              dma_req_o
);

   if (WORD_W < 1) begin : g_bad_w
      $error("word width must be positive");
   end

   logic [WORD_W-1:0] word_q;
   logic              nempty_q;
   logic              ovr_q;
   logic              load;
   logic              drop;

   assign load = word_ready_i && (!nempty_q || rd_i);
   assign drop = word_ready_i && nempty_q && !rd_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q   <= '0;
         nempty_q <= 1'b0;
      end else if (load) begin
         word_q   <= word_i;
         nempty_q <= 1'b1;
      end else if (rd_i) begin
         nempty_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         ovr_q <= 1'b0;
      else if (drop)      ovr_q <= 1'b1;
      else if (ovr_clr_i) ovr_q <= 1'b0;
   end

   if (GEN_DMA) begin : g_dma
      assign dma_req_o = nempty_q && dma_en_i;
   end else begin : g_nodma
      assign dma_req_o = 1'b0;
   end

   assign word_o   = word_q;
   assign nempty_o = nempty_q;
   assign ovr_o    = ovr_q;

   // R6: a read without a new word empties the register
   p_read_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_i && !word_ready_i) |=> !nempty_q);

   // R6: an accepted word is held on the following cycle
   p_load_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (word_ready_i && (!nempty_q || rd_i)) |=> (nempty_q && word_q == $past(word_i)));

   // R7: a word arriving into a full register raises overrun and is lost
   p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (word_ready_i && nempty_q && !rd_i) |=> (ovr_q && $stable(word_q)));

   // R7: overrun is sticky until cleared
   p_ovr_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_q && !ovr_clr_i) |=> ovr_q);

   // R8: no request while DMA is off
   p_dma_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !dma_en_i |-> !dma_req_o);

endmodule

// File: rtl/spdif_word_formatter.sv
module spdif_word_formatter
   import spdif_fmt_pkg::*;
#(
   parameter int SAMPLE_W = 24,
   parameter int WORD_W   = 32,
   parameter int PACK_W   = 16,
   parameter bit GEN_DMA  = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                sf_valid,
   input  logic [SAMPLE_W-1:0] sf_sample,
   input  logic                sf_perr,
   input  logic                sf_valbit,
   input  logic                sf_userbit,
   input  logic                sf_csbit,
   input  logic [1:0]          sf_ptype,
   input  logic [1:0]          cfg_fmt,
   input  logic                cfg_mask_par,
   input  logic                cfg_mask_val,
   input  logic                cfg_mask_cu,
   input  logic                cfg_mask_pt,
   input  logic                cfg_stereo,
   input  logic                cfg_dma_en,
   input  logic                rd_strobe,
   input  logic                ovr_clr,
   output logic [WORD_W-1:0]   dr_word,
   output logic                dr_nempty,
   output logic                ovr_flag,
   output logic                dma_req
);

   stat_t             stat;
   logic              accept;
   logic              hunting;
   logic              word_ready;
   logic [WORD_W-1:0] word;

   assign stat = '{pt: sf_ptype, cs: sf_csbit, user: sf_userbit,
                   valid: sf_valbit, perr: sf_perr};

   spdif_fmt_align u_align (
      .clk       (clk),
      .rst_n     (rst_n),
      .sf_valid_i(sf_valid),
      .pt_i      (sf_ptype),
      .stereo_i  (cfg_stereo),
      .ovr_i     (ovr_flag),
      .ovr_clr_i (ovr_clr),
      .accept_o  (accept),
      .hunting_o (hunting)
   );

   spdif_fmt_build #(
      .SAMPLE_W(SAMPLE_W),
      .WORD_W  (WORD_W),
      .PACK_W  (PACK_W)
   ) u_build (
      .clk         (clk),
      .rst_n       (rst_n),
      .accept_i    (accept),
      .resync_i    (hunting),
      .fmt_i       (cfg_fmt),
      .sample_i    (sf_sample),
      .stat_i      (stat),
      .mask_par_i  (cfg_mask_par),
      .mask_val_i  (cfg_mask_val),
      .mask_cu_i   (cfg_mask_cu),
      .mask_pt_i   (cfg_mask_pt),
      .word_ready_o(word_ready),
      .word_o      (word)
   );

   spdif_fmt_hold #(
      .WORD_W (WORD_W),
      .GEN_DMA(GEN_DMA)
   ) u_hold (
      .clk         (clk),
      .rst_n       (rst_n),
      .word_ready_i(word_ready),
      .word_i      (word),
      .rd_i        (rd_strobe),
      .ovr_clr_i   (ovr_clr),
      .dma_en_i    (cfg_dma_en),
      .word_o      (dr_word),
      .nempty_o    (dr_nempty),
      .ovr_o       (ovr_flag),
      .dma_req_o   (dma_req)
   );

endmodule

// File: tb/spdif_word_formatter_bench.sv
`timescale 1ns/1ps
module spdif_word_formatter_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sf_valid = 1'b0;
   logic [23:0] sf_sample = '0;
   logic        sf_perr = 1'b0, sf_valbit = 1'b0, sf_userbit = 1'b0, sf_csbit = 1'b0;
   logic [1:0]  sf_ptype = 2'b00;
   logic [1:0]  cfg_fmt = 2'd0;
   logic        cfg_mask_par = 1'b0, cfg_mask_val = 1'b0, cfg_mask_cu = 1'b0, cfg_mask_pt = 1'b0;
   logic        cfg_stereo = 1'b0, cfg_dma_en = 1'b0;
   logic        rd_strobe = 1'b0, ovr_clr = 1'b0;
   logic [31:0] dr_word;
   logic        dr_nempty, ovr_flag, dma_req;

   int checks = 0;
   int fails  = 0;
   logic [31:0] expq[$];
   string tag = "R1";

   always #5 clk = ~clk;

   spdif_word_formatter u_spdif_word_formatter (
      .clk(clk), .rst_n(rst_n), .sf_valid(sf_valid), .sf_sample(sf_sample),
      .sf_perr(sf_perr), .sf_valbit(sf_valbit), .sf_userbit(sf_userbit),
      .sf_csbit(sf_csbit), .sf_ptype(sf_ptype), .cfg_fmt(cfg_fmt),
      .cfg_mask_par(cfg_mask_par), .cfg_mask_val(cfg_mask_val),
      .cfg_mask_cu(cfg_mask_cu), .cfg_mask_pt(cfg_mask_pt),
      .cfg_stereo(cfg_stereo), .cfg_dma_en(cfg_dma_en),
      .rd_strobe(rd_strobe), .ovr_clr(ovr_clr), .dr_word(dr_word),
      .dr_nempty(dr_nempty), .ovr_flag(ovr_flag), .dma_req(dma_req)
   );

   task automatic chk(input bit ok, input string t, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s act=%h exp=%h", t, act, exp);
      end
   endtask

   // expected word for layouts 0 and 1, written from R1, R2 and R5
   function automatic logic [31:0] model(input logic [1:0] f, input logic [23:0] d, input logic [5:0] st);
      logic [5:0] m;
      m = st;
      if (cfg_mask_par) m[0] = 1'b0;
      if (cfg_mask_val) m[1] = 1'b0;
      if (cfg_mask_cu)  m[3:2] = 2'b00;
      if (cfg_mask_pt)  m[5:4] = 2'b00;
      if (f == 2'd0) return {2'b00, m, d};
      return {d, 2'b00, m};
   endfunction

   // st = {pt, cs, user, valid, perr}
   task automatic drive_sf(input logic [23:0] d, input logic [5:0] st);
      sf_valid = 1'b1; sf_sample = d;
      sf_perr = st[0]; sf_valbit = st[1]; sf_userbit = st[2]; sf_csbit = st[3];
      sf_ptype = st[5:4];
   endtask

   task automatic send_sf(input logic [23:0] d, input logic [5:0] st);
      @(posedge clk); #1;
      drive_sf(d, st);
      @(posedge clk); #1;
      sf_valid = 1'b0;
   endtask

   task automatic send_exp(input logic [23:0] d, input logic [5:0] st);
      expq.push_back(model(cfg_fmt, d, st));
      send_sf(d, st);
   endtask

   task automatic read_word();
      @(posedge clk); #1; rd_strobe = 1'b1;
      @(posedge clk); #1; rd_strobe = 1'b0;
   endtask

   task automatic clear_ovr();
      @(posedge clk); #1; ovr_clr = 1'b1;
      @(posedge clk); #1; ovr_clr = 1'b0;
   endtask

   // monitor: every read of a full register pops and compares
   always @(negedge clk) begin
      if (rst_n && rd_strobe && dr_nempty) begin
         if (expq.size() == 0) begin
            chk(1'b0, {tag, " unexpected word"}, dr_word, 32'h0);
         end else begin
            logic [31:0] e;
            e = expq.pop_front();
            chk(dr_word == e, tag, dr_word, e);
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      fails++; checks++;
      $display("FAIL watchdog act=%h exp=%h", 32'h0, 32'h1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk); #1;
      // R11 reset state
      chk(dr_word == 0 && !dr_nempty && !ovr_flag && !dma_req, "R11 reset", {dr_word[31:3], dr_nempty, ovr_flag, dma_req}, 32'h0);
      rst_n = 1'b1;

      // R1 right aligned
      tag = "R1"; cfg_fmt = 2'd0;
      send_exp(24'hABCDEF, 6'b10_1011);
      chk(dr_nempty, "R6 not-empty after word", {31'h0, dr_nempty}, 32'h1);
      chk(dr_word == 32'h2BABCDEF, "R1 layout", dr_word, 32'h2BABCDEF);
      read_word();
      chk(!dr_nempty, "R6 read clears", {31'h0, dr_nempty}, 32'h0);
      send_exp(24'h123456, 6'b01_0100); read_word();

      // R2 left aligned
      tag = "R2"; cfg_fmt = 2'd1;
      send_exp(24'h876543, 6'b11_1111);
      chk(dr_word == 32'h8765433F, "R2 layout", dr_word, 32'h8765433F);
      read_word();

      // R5 each mask alone
      tag = "R5"; cfg_fmt = 2'd0;
      cfg_mask_par = 1; send_exp(24'h00F00F, 6'b11_1111); read_word(); cfg_mask_par = 0;
      cfg_mask_val = 1; send_exp(24'h00F00F, 6'b11_1111); read_word(); cfg_mask_val = 0;
      cfg_mask_cu  = 1; send_exp(24'h00F00F, 6'b11_1111); read_word(); cfg_mask_cu  = 0;
      cfg_fmt = 2'd1;
      cfg_mask_pt  = 1; send_exp(24'h5A5A5A, 6'b11_1111);
      chk(dr_word == 32'h5A5A5A0F, "R5 pt mask", dr_word, 32'h5A5A5A0F);
      read_word(); cfg_mask_pt = 0;

      // R3 packed
      tag = "R3"; cfg_fmt = 2'd2;
      send_sf(24'h1111AA, 6'b10_1111);
      chk(!dr_nempty, "R3 first half no word", {31'h0, dr_nempty}, 32'h0);
      expq.push_back(32'h22221111);
      send_sf(24'h2222BB, 6'b11_1111);
      chk(dr_nempty, "R3 second half word", {31'h0, dr_nempty}, 32'h1);
      read_word();

      // R4 reserved
      tag = "R4"; cfg_fmt = 2'd3;
      send_sf(24'h777777, 6'b10_0000);
      send_sf(24'h777777, 6'b11_0000);
      chk(!dr_nempty, "R4 reserved silent", {31'h0, dr_nempty}, 32'h0);

      // R8 DMA
      tag = "R8"; cfg_fmt = 2'd0; cfg_dma_en = 1;
      send_exp(24'h000001, 6'b10_0000);
      chk(dma_req, "R8 request with data", {31'h0, dma_req}, 32'h1);
      cfg_dma_en = 0; #1;
      chk(!dma_req, "R8 disabled", {31'h0, dma_req}, 32'h0);
      cfg_dma_en = 1;
      read_word();
      chk(!dma_req, "R8 after read", {31'h0, dma_req}, 32'h0);
      cfg_dma_en = 0;

      // R6 read and new word on the same edge
      tag = "R6";
      send_exp(24'h0000A1, 6'b10_0000);
      @(posedge clk); #1;
      expq.push_back(model(cfg_fmt, 24'h0000A2, 6'b11_0000));
      drive_sf(24'h0000A2, 6'b11_0000); rd_strobe = 1'b1;
      @(posedge clk); #1;
      sf_valid = 1'b0; rd_strobe = 1'b0;
      chk(dr_nempty && !ovr_flag, "R6 collision keeps new, no overrun", {30'h0, dr_nempty, ovr_flag}, 32'h2);
      read_word();

      // R7 overrun
      tag = "R7";
      send_exp(24'h0000B1, 6'b10_0000);
      send_sf(24'h0000B2, 6'b11_0000);
      chk(ovr_flag, "R7 overrun set", {31'h0, ovr_flag}, 32'h1);
      chk(dr_word == model(2'd0, 24'h0000B1, 6'b10_0000), "R7 held word kept", dr_word, model(2'd0, 24'h0000B1, 6'b10_0000));
      read_word();
      chk(ovr_flag, "R7 sticky", {31'h0, ovr_flag}, 32'h1);
      clear_ovr();
      chk(!ovr_flag, "R7 cleared", {31'h0, ovr_flag}, 32'h0);

      // R9 stereo realignment
      tag = "R9"; cfg_stereo = 1;
      send_exp(24'h0000C1, 6'b10_0000);
      send_sf(24'h0000C2, 6'b11_0000);
      read_word(); clear_ovr();
      send_sf(24'h0000C3, 6'b11_0000);
      chk(!dr_nempty, "R9 channel B skipped", {31'h0, dr_nempty}, 32'h0);
      send_exp(24'h0000C4, 6'b01_0000);
      chk(dr_nempty, "R9 channel A taken", {31'h0, dr_nempty}, 32'h1);
      read_word();
      send_exp(24'h0000C5, 6'b11_0000); read_word();

      // R9 stereo packed restarts pair on channel A
      cfg_fmt = 2'd2;
      expq.push_back(32'h00D200D1);
      send_sf(24'h00D1FF, 6'b10_0000); send_sf(24'h00D2FF, 6'b11_0000);
      send_sf(24'h00D3FF, 6'b10_0000); send_sf(24'h00D4FF, 6'b11_0000);
      send_sf(24'h00D5FF, 6'b10_0000);
      read_word(); clear_ovr();
      send_sf(24'h00E0FF, 6'b11_0000);
      expq.push_back(32'h00E200E1);
      send_sf(24'h00E1FF, 6'b10_0000); send_sf(24'h00E2FF, 6'b11_0000);
      chk(dr_word == 32'h00E200E1, "R9 packed realigned", dr_word, 32'h00E200E1);
      read_word();

      // R10 mono: no realignment
      tag = "R10"; cfg_fmt = 2'd0; cfg_stereo = 0;
      send_exp(24'h0000F1, 6'b10_0000);
      send_sf(24'h0000F2, 6'b11_0000);
      read_word(); clear_ovr();
      send_exp(24'h0000F3, 6'b11_0000);
      chk(dr_nempty, "R10 channel B used", {31'h0, dr_nempty}, 32'h1);
      read_word();

      repeat (2) @(posedge clk);
      chk(expq.size() == 0, "R6 all expected words read", expq.size(), 32'h0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule